// File: doc/BRIEF.md
# Power Mode Clock Controller

This block derives two clocks for a subsystem from two free-running sources: a fast clock and a slow clock of nominally 32768 Hz. The first output is a master clock that feeds the peripherals. The second is a processor clock, which is a gated copy of the master clock. Four operating modes decide which source feeds the master clock and whether the processor clock runs. Software requests a mode by presenting a code together with a one-cycle valid strobe. An interrupt line restarts a stopped processor.

Moving the master clock from one source to the other follows a handshake. The running source is first turned off. Only after the domain of the other source has seen it off is the new source turned on. Each enable changes while its own clock is low, so the master clock never carries a pulse shorter than the half period of the source that produced it. The processor clock is gated through a level-sensitive enable that is open only while the master clock is low. A completion flag tells software when the master clock really comes from the source that the current mode asks for.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the mode code is 0 (run), the master clock comes from the fast source, the processor clock runs and switch_done is 1.
- R2: When mode_req_valid is sampled high on a fast clock edge and irq is low, cur_mode takes mode_req on that edge. The codes are 0 = run, 1 = doze, 2 = slow run, 3 = slow doze. Bit 1 selects the slow source and bit 0 stops the processor.
- R3: In the doze code the master clock keeps toggling at the fast rate and the processor clock has no edges.
- R4: When irq is sampled high while cur_mode bit 0 is 1, the next mode clears bit 0. Doze returns to run, and slow doze returns to slow run.
- R5: An irq sampled while cur_mode bit 0 is 0 and no request is present leaves cur_mode unchanged.
- R6: In the slow codes the master clock toggles at the slow source rate. In slow run the processor clock follows it.
- R7: No high or low phase of the master clock is shorter than the half period of the fast source.
- R8: The fast and slow source enables are never active together.
- R9: switch_done is 0 from the cycle after a request that changes the source bit until the new source drives the master clock, and it returns to 1 once it does.
- R10: When irq and a request with bit 0 set are sampled on the same edge, the requested source bit is taken, bit 0 ends at 0, and the processor clock keeps running.
- R11: Whenever the processor clock is enabled, it has exactly the same edges as the master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast source clock; also clocks the mode logic |
| slow_clk | input | 1 | Slow source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_valid | input | 1 | One-cycle strobe that loads mode_req |
| mode_req | input | 2 | Requested mode code |
| irq | input | 1 | Interrupt that wakes a stopped processor |
| mst_clk | output | 1 | Master clock for the peripherals |
| cpu_clk | output | 1 | Gated processor clock |
| cur_mode | output | 2 | Current mode code |
| switch_done | output | 1 | Master clock is on the source the mode selects |

## Verification
A software request that stops the processor and a waking interrupt can be sampled on the same fast clock edge. In that case the mode logic has to keep the requested source bit and still clear the stop bit. The bench drives both inputs in a single cycle, both from run and from slow run. It then checks that the mode code has bit 0 clear and the source bit requested. It also checks that the processor clock has the same number of edges as the master clock over a measuring window. The randomized sequence raises irq about one step in four, together with random requests, so that this collision also happens in states the bench did not aim at.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_RUN  = 2'b00,
    PM_DOZE = 2'b01,
    PM_SLOW = 2'b10,
    PM_SDOZ = 2'b11
  } pm_mode_e;

  // Next mode from the current code, a request and the wake line.
  function automatic logic [MODE_W-1:0] pm_next(
    input logic [MODE_W-1:0] cur,
    input logic              req_valid,
    input logic [MODE_W-1:0] req,
    input logic              wake
  );
    logic [MODE_W-1:0] nxt;
    nxt = req_valid ? req : cur;
    if (wake) nxt[0] = 1'b0;
    return nxt;
  endfunction

  function automatic logic pm_uses_slow(input logic [MODE_W-1:0] m);
    return m[1];
  endfunction

  function automatic logic pm_cpu_on(input logic [MODE_W-1:0] m);
    return ~m[0];
  endfunction

endpackage

// File: rtl/pmc_sync.sv
`timescale 1ns/1ps
module pmc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pmc_mode_fsm.sv
`timescale 1ns/1ps
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req,
  input  logic              irq,
  output logic [MODE_W-1:0] mode,
  output logic              wake_evt
);

  logic [MODE_W-1:0] mode_nxt;

  // A wake is only meaningful when the processor is stopped or about to stop.
  assign wake_evt = irq & (mode[0] | (req_valid & req[0]));
  assign mode_nxt = pm_next(mode, req_valid, req, irq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= PM_RUN;
    else        mode <= mode_nxt;
  end

  a_r2_load_request: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !irq) |=> (mode == $past(req)));

  a_r4_wake_clears_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && irq) |=> !mode[0]);

  a_r5_irq_ignored_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && irq && !req_valid) |=> $stable(mode));

  a_r10_irq_beats_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req[0] && irq) |=> (!mode[0] && mode[1] == $past(req[1])));

endmodule

// File: rtl/pmc_clk_switch.sv
`timescale 1ns/1ps
module pmc_clk_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic fast_clk,
  input  logic slow_clk,
  input  logic rst_n,
  input  logic sel_slow,
  output logic mst_clk,
  output logic fast_on,
  output logic slow_on,
  output logic done
);

  logic f_req, f_arm;
  logic s_req, s_arm;
  logic slow_seen;

  // Fast side: may enable only while the slow side reports off.
  assign f_req = ~sel_slow & ~slow_on;

  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_fast_arm (
    .clk(fast_clk), .rst_n(rst_n), .d(f_req), .q(f_arm)
  );

  always_ff @(negedge fast_clk or negedge rst_n) begin
    if (!rst_n) fast_on <= 1'b1;
    else        fast_on <= f_arm;
  end

  // Slow side: may enable only while the fast side reports off.
  assign s_req = sel_slow & ~fast_on;

  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_slow_arm (
    .clk(slow_clk), .rst_n(rst_n), .d(s_req), .q(s_arm)
  );

  always_ff @(negedge slow_clk or negedge rst_n) begin
    if (!rst_n) slow_on <= 1'b0;
    else        slow_on <= s_arm;
  end

  // Slow enable as seen from the fast domain, for completion tracking.
  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_slow_seen (
    .clk(fast_clk), .rst_n(rst_n), .d(slow_on), .q(slow_seen)
  );

  assign mst_clk = (fast_clk & fast_on) | (slow_clk & slow_on);
  assign done    = sel_slow ? (slow_seen & ~fast_on) : (fast_on & ~slow_seen);

  a_r8_one_source: assert property (@(posedge fast_clk) disable iff (!rst_n)
    !(fast_on && slow_on));

endmodule

// File: rtl/pmc_clk_gate.sv
`timescale 1ns/1ps
module pmc_clk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic run_req,
  output logic clk_out,
  output logic run_sync
);

  logic en_lat;

  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_run_sync (
    .clk(clk_in), .rst_n(rst_n), .d(run_req), .q(run_sync)
  );

  // Transparent only while the clock is low, so the enable never cuts a high phase.
  always_latch begin
    if (!rst_n)       en_lat = 1'b1;
    else if (!clk_in) en_lat = run_sync;
  end

  assign clk_out = clk_in & en_lat;

endmodule

// File: rtl/pwr_clk_ctrl.sv
`timescale 1ns/1ps
module pwr_clk_ctrl
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              fast_clk,
  input  logic              slow_clk,
  input  logic              rst_n,
  input  logic              mode_req_valid,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              irq,
  output logic              mst_clk,
  output logic              cpu_clk,
  output logic [MODE_W-1:0] cur_mode,
  output logic              switch_done
);

  logic [MODE_W-1:0] mode;
  logic              wake_evt;
  logic              sel_eff;
  logic              sw_done_raw;
  logic              fast_on, slow_on;
  logic              cpu_run_sync;
  logic              want_slow;

  pmc_mode_fsm u_fsm (
    .clk(fast_clk), .rst_n(rst_n), .req_valid(mode_req_valid),
    .req(mode_req), .irq(irq), .mode(mode), .wake_evt(wake_evt)
  );

  assign want_slow = pm_uses_slow(mode);

  // The source select moves only after the previous handover has finished.
  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n)                                sel_eff <= 1'b0;
    else if (sw_done_raw && sel_eff != want_slow) sel_eff <= want_slow;
  end

  pmc_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
    .fast_clk(fast_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .sel_slow(sel_eff), .mst_clk(mst_clk), .fast_on(fast_on),
    .slow_on(slow_on), .done(sw_done_raw)
  );

  pmc_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk_in(mst_clk), .rst_n(rst_n), .run_req(pm_cpu_on(mode)),
    .clk_out(cpu_clk), .run_sync(cpu_run_sync)
  );

  assign cur_mode    = mode;
  assign switch_done = sw_done_raw & (sel_eff == want_slow);

  a_r9_busy_after_turn: assert property (@(posedge fast_clk) disable iff (!rst_n)
    (sel_eff != $past(sel_eff)) |-> !sw_done_raw);

  a_r9_done_matches_source: assert property (@(posedge fast_clk) disable iff (!rst_n)
    switch_done |-> (sel_eff ? !fast_on : !slow_on));

endmodule

// File: tb/pwr_clk_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_tb;

  logic       fast_clk = 1'b0;
  logic       slow_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_req_valid = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic       irq = 1'b0;
  wire        mst_clk, cpu_clk, switch_done;
  wire  [1:0] cur_mode;

  pwr_clk_ctrl u_dut (
    .fast_clk(fast_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .mode_req_valid(mode_req_valid), .mode_req(mode_req), .irq(irq),
    .mst_clk(mst_clk), .cpu_clk(cpu_clk), .cur_mode(cur_mode),
    .switch_done(switch_done)
  );

  always #2.5 fast_clk = ~fast_clk;
  initial begin
    #3;
    forever #20 slow_clk = ~slow_clk;
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [1:0] exp_mode = 2'b00;

  int n_mst = 0;
  int n_cpu = 0;
  always @(posedge mst_clk) n_mst++;
  always @(posedge cpu_clk) n_cpu++;

  // Pulse-width monitor on the master clock.
  bit      mon_on = 1'b0;
  bit      seen_edge = 1'b0;
  realtime last_t = 0.0;
  realtime min_w = 1.0e9;
  always @(mst_clk) begin
    if (mon_on) begin
      if (seen_edge && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
      seen_edge = 1'b1;
      last_t = $realtime;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] model_next(input logic [1:0] cur, input bit v,
                                            input logic [1:0] r, input bit w);
    logic [1:0] n;
    if (v) n = r; else n = cur;
    if (w && (n[0] || cur[0])) n = {n[1], 1'b0};
    return n;
  endfunction

  task automatic measure(output int m, output int c);
    int a0, b0;
    a0 = n_mst; b0 = n_cpu;
    #400;
    m = n_mst - a0;
    c = n_cpu - b0;
  endtask

  task automatic apply(input bit v, input logic [1:0] r, input bit w);
    @(negedge fast_clk);
    mode_req_valid = v; mode_req = r; irq = w;
    @(negedge fast_clk);
    mode_req_valid = 1'b0; irq = 1'b0;
    exp_mode = model_next(exp_mode, v, r, w);
  endtask

  task automatic verify(input string tag);
    int m, c;
    repeat (100) @(posedge fast_clk);
    #1;
    chk(cur_mode == exp_mode, {tag, " R2 R4 R5 mode"}, cur_mode, exp_mode);
    chk(switch_done == 1'b1, {tag, " R9 done settled"}, switch_done, 1);
    measure(m, c);
    if (exp_mode[1]) chk(m >= 9 && m <= 11, {tag, " R6 slow master rate"}, m, 10);
    else             chk(m >= 77 && m <= 83, {tag, " R3 fast master rate"}, m, 80);
    if (exp_mode[0]) chk(c == 0, {tag, " R3 cpu stopped"}, c, 0);
    else             chk(c == m, {tag, " R11 cpu follows master"}, c, m);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int m, c;
    void'($urandom(32'h5eed_0042));
    #23 rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (10) @(posedge fast_clk);
    #1;
    // R1 reset state
    chk(cur_mode == 2'b00, "R1 mode after reset", cur_mode, 0);
    chk(switch_done == 1'b1, "R1 done after reset", switch_done, 1);
    measure(m, c);
    chk(m >= 77 && m <= 83, "R1 fast master after reset", m, 80);
    chk(c == m, "R1 cpu running after reset", c, m);

    // R2 and R9: request slow run, done must drop during handover
    @(negedge fast_clk);
    mode_req_valid = 1'b1; mode_req = 2'b10;
    @(posedge fast_clk);
    @(posedge fast_clk);
    #1;
    chk(switch_done == 1'b0, "R9 busy during handover", switch_done, 0);
    chk(cur_mode == 2'b10, "R2 request loaded", cur_mode, 2);
    @(negedge fast_clk);
    mode_req_valid = 1'b0;
    exp_mode = 2'b10;
    verify("slow run R6");

    // Back to run, then doze
    apply(1'b1, 2'b00, 1'b0); verify("run");
    apply(1'b1, 2'b01, 1'b0); verify("doze R3");
    // R4 wake from doze to run
    apply(1'b0, 2'b00, 1'b1); verify("wake doze R4");
    // R5 irq in run ignored
    apply(1'b0, 2'b00, 1'b1); verify("irq in run R5");
    // slow doze then wake to slow run (R4)
    apply(1'b1, 2'b11, 1'b0); verify("slow doze R3");
    apply(1'b0, 2'b00, 1'b1); verify("wake slow doze R4");
    // R5 irq in slow run ignored
    apply(1'b0, 2'b00, 1'b1); verify("irq in slow run R5");
    // R10 collisions
    apply(1'b1, 2'b01, 1'b1); verify("collision to doze R10");
    chk(cur_mode == 2'b00, "R10 stop cancelled, fast", cur_mode, 0);
    apply(1'b1, 2'b11, 1'b1); verify("collision to slow doze R10");
    chk(cur_mode == 2'b10, "R10 stop cancelled, slow", cur_mode, 2);

    // Random sequence
    for (int i = 0; i < 40; i++) begin
      bit v, w;
      logic [1:0] r;
      v = ($urandom % 4) != 0;
      r = 2'($urandom % 4);
      w = ($urandom % 4) == 0;
      apply(v, r, w);
      verify("random");
    end

    // R7 and R8 (both sources never overlap, so no short pulse appears)
    chk(min_w >= 2.4, "R7 R8 minimum master phase (ps)", int'(min_w * 1000.0), 2500);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule